// File: doc/BRIEF.md
# Line CFAR Detector

This block runs a one-dimensional constant-false-alarm-rate test over a single line of unsigned magnitude cells. The line can be a range line or a Doppler line; the block handles both the same way and reports the direction it was told. A line is streamed in one cell per valid beat and held locally. Each cell is then tested in turn. The noise near a cell under test is estimated from a window of cells before it and a window of cells after it. Guard cells keep each window away from the cell under test.

Each window sum is divided by a power of two using a right shift. The two window averages are then combined by one of three modes: their mean, the larger, or the smaller. The combined noise is multiplied by an unsigned fixed-point scale. A cell is a detection when its magnitude is strictly above that product.

Configuration is sampled when a line starts. Windows can wrap around the ends of the line, or they can be clipped to the side that is present. An optional peak filter keeps only cells that are local maxima. Detections leave in index order, and the last detection of a line carries a marker.

Top module: `cfar_line`

## Requirements
- R1: A line starts with a beat that has `in_valid` and `in_first` high. That beat is cell 0, and the following `in_valid` beats are cells 1 upward in arrival order. All `cfg_*` inputs are captured on the first beat. After `cfg_len` cells, `busy` rises and stays high until the line is finished. While `busy` is high, input beats and configuration changes have no effect on the current line.
- R2: For the cell at index i, with guard g and window w, the lagging window is cells i-g-w to i-g-1 and the leading window is cells i+g+1 to i+g+w. Each window sum is shifted right by `cfg_shift` to form that side's average.
- R3: `cfg_mode` selects how the two averages are combined. With 0 the noise is floor((lag+lead)/2). With 1 it is the larger average, and with 2 it is the smaller. Value 3 behaves as 0.
- R4: A cell is detected only if cell*2^FRAC is strictly greater than noise*`cfg_scale`, where `cfg_scale` is unsigned with FRAC fractional bits (FRAC=4 by default, so 0x30 means 3.0).
- R5: With `cfg_cyclic`=0, a side is used only if its whole window lies inside the line. When only one side is usable, the noise is that side's average in every mode. When neither side is usable, the cell is not reported.
- R6: With `cfg_cyclic`=1, window indices wrap modulo `cfg_len`, so both sides are always used. This requires g+w < `cfg_len`.
- R7: With `cfg_group`=1, a cell that passes the threshold is reported only if it is greater than or equal to each neighbour. Neighbours wrap in cyclic mode. In non-cyclic mode a missing neighbour at an edge is ignored.
- R8: Each detection is a one-cycle `det_valid` pulse carrying the index, the cell value and the noise estimate. Detections come out in increasing index order. Only the last detection of a line has `det_last`=1. `det_dir` repeats the direction captured for the line. A line with no detections produces no pulse.
- R9: While reset is asserted and directly after it, `det_valid` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dir | input | 1 | Line direction, 0 range, 1 Doppler |
| cfg_mode | input | 2 | Noise combining mode |
| cfg_win | input | WW (5) | One-sided window length, at least 1 |
| cfg_guard | input | GW (4) | One-sided guard length |
| cfg_shift | input | SH_W (5) | Right shift applied to each window sum |
| cfg_cyclic | input | 1 | Wrap windows around the line ends |
| cfg_group | input | 1 | Keep only local maxima |
| cfg_scale | input | SC_W (8) | Threshold factor, FRAC fractional bits |
| cfg_len | input | LW (7) | Cells in the line, 1 to LEN_MAX |
| in_valid | input | 1 | Cell beat valid |
| in_first | input | 1 | Beat is cell 0 of a new line |
| in_cell | input | CELL_W (16) | Cell magnitude |
| busy | output | 1 | Line being processed; input ignored |
| det_valid | output | 1 | Detection pulse |
| det_last | output | 1 | Final detection of the line |
| det_dir | output | 1 | Direction of the line |
| det_idx | output | AW (6) | Index of the detected cell |
| det_cell | output | CELL_W (16) | Magnitude of the detected cell |
| det_noise | output | SUM_W (21) | Noise estimate used for the test |

## Verification
A flat floor with isolated spikes confirms where the windows sit and how the strict threshold behaves. Cells placed exactly at the threshold and one step above it separate strict from non-strict comparison. A raised block on only one side of a spike gives three different outcomes for the mean, greater-of and smaller-of modes. Raised cells at the far end of the line, with a spike near the start, produce different noise values with and without wrapping. Two adjacent spikes show whether the peak filter drops the smaller one. Junk beats and configuration changes driven while the block is busy must leave the result unchanged.

// File: rtl/cfar_line.sv
module cfar_line #(
  parameter int CELL_W  = 16,
  parameter int LEN_MAX = 64,
  parameter int WIN_MAX = 16,
  parameter int GRD_MAX = 15,
  parameter int SC_W    = 8,
  parameter int FRAC    = 4,
  localparam int AW    = $clog2(LEN_MAX),
  localparam int LW    = $clog2(LEN_MAX + 1),
  localparam int WW    = $clog2(WIN_MAX + 1),
  localparam int GW    = $clog2(GRD_MAX + 1),
  localparam int SUM_W = CELL_W + WW,
  localparam int SH_W  = $clog2(SUM_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dir,
  input  logic [1:0]        cfg_mode,
  input  logic [WW-1:0]     cfg_win,
  input  logic [GW-1:0]     cfg_guard,
  input  logic [SH_W-1:0]   cfg_shift,
  input  logic              cfg_cyclic,
  input  logic              cfg_group,
  input  logic [SC_W-1:0]   cfg_scale,
  input  logic [LW-1:0]     cfg_len,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [CELL_W-1:0] in_cell,
  output logic              busy,
  output logic              det_valid,
  output logic              det_last,
  output logic              det_dir,
  output logic [AW-1:0]     det_idx,
  output logic [CELL_W-1:0] det_cell,
  output logic [SUM_W-1:0]  det_noise
);
  localparam int PW = SUM_W + SC_W;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SCAN, S_DECIDE, S_FLUSH} st_t;
  st_t st;

  logic [CELL_W-1:0] mem [LEN_MAX];
  logic [LW-1:0]     len_q;
  logic [1:0]        mode_q;
  logic [WW-1:0]     win_q;
  logic [GW-1:0]     grd_q;
  logic [SH_W-1:0]   sh_q;
  logic              cyc_q, grp_q, dir_q;
  logic [SC_W-1:0]   sc_q;

  logic [AW-1:0]     wptr, cut, rd_idx, nb_l, nb_r;
  logic [WW:0]       k;
  logic [SUM_W-1:0]  sum_lag, sum_lead;

  logic              pend_v;
  logic [AW-1:0]     pend_idx;
  logic [CELL_W-1:0] pend_cell;
  logic [SUM_W-1:0]  pend_noise;

  assign busy = (st == S_SCAN) || (st == S_DECIDE) || (st == S_FLUSH);

  always_comb begin
    int pos;
    int ln;
    ln = int'(len_q);
    if (int'(k) < int'(win_q)) pos = int'(cut) - int'(grd_q) - 1 - int'(k);
    else                       pos = int'(cut) + int'(grd_q) + 1 + int'(k) - int'(win_q);
    if (pos < 0)        pos = pos + ln;
    else if (pos >= ln) pos = pos - ln;
    rd_idx = AW'(pos);
  end

  logic lag_ok, lead_ok, last_cut;
  assign last_cut = (int'(cut) == int'(len_q) - 1);
  assign lag_ok   = cyc_q || (int'(cut) >= int'(grd_q) + int'(win_q));
  assign lead_ok  = cyc_q || (int'(cut) + int'(grd_q) + int'(win_q) <= int'(len_q) - 1);
  assign nb_l     = (cut == '0) ? AW'(int'(len_q) - 1) : cut - AW'(1);
  assign nb_r     = last_cut ? '0 : cut + AW'(1);

  logic [SUM_W-1:0]  avg_lag, avg_lead, avg_mean, noise;
  logic [CELL_W-1:0] cell_cut;
  logic [PW-1:0]     cell_sc, thr;
  logic              peak, hit;

  assign avg_lag  = sum_lag  >> sh_q;
  assign avg_lead = sum_lead >> sh_q;
  assign avg_mean = SUM_W'(({1'b0, avg_lag} + {1'b0, avg_lead}) >> 1);
  assign cell_cut = mem[cut];

  always_comb begin
    if (lag_ok && lead_ok) begin
      case (mode_q)
        2'd1:    noise = (avg_lag > avg_lead) ? avg_lag : avg_lead;
        2'd2:    noise = (avg_lag < avg_lead) ? avg_lag : avg_lead;
        default: noise = avg_mean;
      endcase
    end else if (lag_ok) noise = avg_lag;
    else                 noise = avg_lead;
  end

  assign cell_sc = {{(PW - CELL_W - FRAC){1'b0}}, cell_cut, {FRAC{1'b0}}};
  assign thr     = PW'(noise) * PW'(sc_q);
  assign peak    = ((!cyc_q && cut == '0) || cell_cut >= mem[nb_l]) &&
                   ((!cyc_q && last_cut)  || cell_cut >= mem[nb_r]);
  assign hit     = (lag_ok || lead_ok) && (cell_sc > thr) && (!grp_q || peak);

  always_ff @(posedge clk) begin
    if (in_valid && !busy) begin
      if (in_first)            mem[0]    <= in_cell;
      else if (st == S_LOAD)   mem[wptr] <= in_cell;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      len_q <= '0; mode_q <= '0; win_q <= '0; grd_q <= '0; sh_q <= '0;
      cyc_q <= 1'b0; grp_q <= 1'b0; dir_q <= 1'b0; sc_q <= '0;
      wptr <= '0; cut <= '0; k <= '0; sum_lag <= '0; sum_lead <= '0;
      pend_v <= 1'b0; pend_idx <= '0; pend_cell <= '0; pend_noise <= '0;
      det_valid <= 1'b0; det_last <= 1'b0; det_dir <= 1'b0;
      det_idx <= '0; det_cell <= '0; det_noise <= '0;
    end else begin
      det_valid <= 1'b0;
      det_last  <= 1'b0;
      case (st)
        S_IDLE, S_LOAD: begin
          if (in_valid && in_first) begin
            len_q <= cfg_len; mode_q <= cfg_mode; win_q <= cfg_win;
            grd_q <= cfg_guard; sh_q <= cfg_shift; cyc_q <= cfg_cyclic;
            grp_q <= cfg_group; dir_q <= cfg_dir; sc_q <= cfg_scale;
            wptr  <= AW'(1);
            cut <= '0; k <= '0; sum_lag <= '0; sum_lead <= '0; pend_v <= 1'b0;
            st <= (int'(cfg_len) <= 1) ? S_SCAN : S_LOAD;
          end else if (in_valid && st == S_LOAD) begin
            wptr <= wptr + AW'(1);
            if (int'(wptr) + 1 >= int'(len_q)) st <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (int'(k) < int'(win_q)) sum_lag  <= sum_lag  + SUM_W'(mem[rd_idx]);
          else                       sum_lead <= sum_lead + SUM_W'(mem[rd_idx]);
          k <= k + 1'b1;
          if (int'(k) >= 2 * int'(win_q) - 1) st <= S_DECIDE;
        end
        S_DECIDE: begin
          if (hit) begin
            if (pend_v) begin
              det_valid <= 1'b1; det_dir <= dir_q;
              det_idx <= pend_idx; det_cell <= pend_cell; det_noise <= pend_noise;
            end
            pend_v <= 1'b1; pend_idx <= cut; pend_cell <= cell_cut; pend_noise <= noise;
          end
          k <= '0; sum_lag <= '0; sum_lead <= '0;
          if (last_cut) st <= S_FLUSH;
          else begin
            cut <= cut + AW'(1);
            st  <= S_SCAN;
          end
        end
        S_FLUSH: begin
          if (pend_v) begin
            det_valid <= 1'b1; det_last <= 1'b1; det_dir <= dir_q;
            det_idx <= pend_idx; det_cell <= pend_cell; det_noise <= pend_noise;
          end
          pend_v <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfar_line_chk.sv
module cfar_line_chk #(
  parameter int CELL_W = 16,
  parameter int AW     = 6,
  parameter int LW     = 7,
  parameter int SUM_W  = 21,
  parameter int SC_W   = 8,
  parameter int FRAC   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              det_valid,
  input logic              det_last,
  input logic [AW-1:0]     det_idx,
  input logic [CELL_W-1:0] det_cell,
  input logic [SUM_W-1:0]  det_noise,
  input logic [LW-1:0]     len_q,
  input logic [SC_W-1:0]   sc_q
);
  localparam int PW = SUM_W + SC_W;

  a_r8_idx_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> int'(det_idx) < int'(len_q));

  a_r4_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> ({{(PW - CELL_W - FRAC){1'b0}}, det_cell, {FRAC{1'b0}}} >
                   (PW'(det_noise) * PW'(sc_q))));

  a_r8_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_last) |-> !busy);

  a_r8_last_single: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && det_last) |=> !det_valid);

  a_r1_mid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && !det_last) |-> busy);
endmodule

bind cfar_line cfar_line_chk #(
  .CELL_W(CELL_W), .AW(AW), .LW(LW), .SUM_W(SUM_W), .SC_W(SC_W), .FRAC(FRAC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .det_valid(det_valid),
  .det_last(det_last), .det_idx(det_idx), .det_cell(det_cell),
  .det_noise(det_noise), .len_q(len_q), .sc_q(sc_q)
);

// File: tb/cfar_line_test.sv
module cfar_line_test;
  localparam int CELL_W = 16, LEN_MAX = 64, FRAC = 4;
  localparam int AW = 6, LW = 7, WW = 5, GW = 4, SUM_W = 21, SH_W = 5, SC_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cfg_dir = 0, cfg_cyclic = 0, cfg_group = 0;
  logic [1:0]        cfg_mode = 0;
  logic [WW-1:0]     cfg_win = 4;
  logic [GW-1:0]     cfg_guard = 1;
  logic [SH_W-1:0]   cfg_shift = 2;
  logic [SC_W-1:0]   cfg_scale = 8'h30;
  logic [LW-1:0]     cfg_len = 32;
  logic              in_valid = 0, in_first = 0;
  logic [CELL_W-1:0] in_cell = 0;
  logic              busy, det_valid, det_last, det_dir;
  logic [AW-1:0]     det_idx;
  logic [CELL_W-1:0] det_cell;
  logic [SUM_W-1:0]  det_noise;

  cfar_line uut (.*);

  int checks = 0, fails = 0;
  int line_v [LEN_MAX];
  int cap_n, cap_idx [LEN_MAX], cap_cell [LEN_MAX], cap_noise [LEN_MAX], cap_last [LEN_MAX], cap_dir [LEN_MAX];
  int exp_n, exp_idx [LEN_MAX], exp_cell [LEN_MAX], exp_noise [LEN_MAX];
  int cycles = 0;

  always @(negedge clk) begin
    cycles++;
    if (det_valid && cap_n < LEN_MAX) begin
      cap_idx[cap_n] = int'(det_idx); cap_cell[cap_n] = int'(det_cell);
      cap_noise[cap_n] = int'(det_noise); cap_last[cap_n] = int'(det_last);
      cap_dir[cap_n] = int'(det_dir);
      cap_n++;
    end
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int pat_val(input int p, input int j);
    case (p)
      0: return (j == 10) ? 100 : (j == 25) ? 60 : 8;
      1: return (j == 1) ? 100 : (j >= 28) ? 40 : 8;
      2: return (j == 10) ? 50 : (j >= 12 && j <= 15) ? 20 : 8;
      3: return (j == 10) ? 100 : (j == 11) ? 90 : 8;
      4: return ((j * 37) % 23) + ((j == 17) ? 200 : 0) + ((j == 40) ? 150 : 0);
      default: return (j == 8) ? 24 : (j == 20) ? 25 : 8;
    endcase
  endfunction

  function automatic int wrapi(input int x, input int n);
    int r;
    r = x;
    while (r < 0) r += n;
    while (r >= n) r -= n;
    return r;
  endfunction

  task automatic model();
    int n, w, g, sh, md, cyc, grp, sc;
    n = int'(cfg_len); w = int'(cfg_win); g = int'(cfg_guard); sh = int'(cfg_shift);
    md = int'(cfg_mode); cyc = int'(cfg_cyclic); grp = int'(cfg_group); sc = int'(cfg_scale);
    exp_n = 0;
    for (int i = 0; i < n; i++) begin
      int sl, sr, al, ar, nz, lok, rok, pk, c;
      sl = 0; sr = 0;
      for (int q = 1; q <= w; q++) begin
        sl += line_v[wrapi(i - g - q, n)];
        sr += line_v[wrapi(i + g + q, n)];
      end
      al = sl >>> sh; ar = sr >>> sh;
      lok = (cyc != 0) || (i - g - w >= 0);
      rok = (cyc != 0) || (i + g + w <= n - 1);
      if (lok && rok) nz = (md == 1) ? ((al > ar) ? al : ar) : (md == 2) ? ((al < ar) ? al : ar) : (al + ar) / 2;
      else nz = lok ? al : ar;
      c = line_v[i];
      pk = 1;
      if ((cyc != 0 || i > 0) && c < line_v[wrapi(i - 1, n)]) pk = 0;
      if ((cyc != 0 || i < n - 1) && c < line_v[wrapi(i + 1, n)]) pk = 0;
      if ((lok || rok) && (c * (1 << FRAC) > nz * sc) && (grp == 0 || pk != 0)) begin
        exp_idx[exp_n] = i; exp_cell[exp_n] = c; exp_noise[exp_n] = nz; exp_n++;
      end
    end
  endtask

  task automatic run_line(input int p, input bit junk);
    int n;
    n = int'(cfg_len);
    for (int j = 0; j < n; j++) line_v[j] = pat_val(p, j);
    model();
    cap_n = 0;
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      in_valid = 1; in_first = (j == 0); in_cell = CELL_W'(line_v[j]);
      @(negedge clk);
    end
    in_valid = 0; in_first = 0;
    if (junk) begin
      logic [1:0] m_save;
      m_save = cfg_mode;
      cfg_mode = 2'd1; in_valid = 1; in_first = 1; in_cell = 16'd999;
      repeat (5) @(negedge clk);
      in_valid = 0; in_first = 0; cfg_mode = m_save;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R8 detection count"}, cap_n, exp_n);
    for (int d = 0; d < exp_n && d < cap_n; d++) begin
      chk({tag, " R2 index"}, cap_idx[d], exp_idx[d]);
      chk({tag, " R8 cell"}, cap_cell[d], exp_cell[d]);
      chk({tag, " R3 noise"}, cap_noise[d], exp_noise[d]);
      chk({tag, " R8 last marker"}, cap_last[d], (d == exp_n - 1) ? 1 : 0);
      chk({tag, " R8 direction"}, cap_dir[d], int'(cfg_dir));
    end
  endtask

  function automatic int find(input int idx);
    for (int d = 0; d < cap_n; d++) if (cap_idx[d] == idx) return d;
    return -1;
  endfunction

  typedef struct packed {
    logic [1:0] mode; logic [4:0] win; logic [3:0] grd; logic [4:0] sh;
    logic cyc; logic grp; logic [7:0] sc; logic [2:0] pat; logic [6:0] len; logic dir;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 5'd4, 4'd1, 5'd2, 1'b0, 1'b0, 8'h30, 3'd0, 7'd32, 1'b0},
    '{2'd1, 5'd4, 4'd2, 5'd2, 1'b1, 1'b0, 8'h20, 3'd4, 7'd48, 1'b1},
    '{2'd2, 5'd2, 4'd0, 5'd1, 1'b0, 1'b0, 8'h28, 3'd4, 7'd48, 1'b0},
    '{2'd0, 5'd8, 4'd2, 5'd3, 1'b1, 1'b1, 8'h18, 3'd4, 7'd64, 1'b1},
    '{2'd3, 5'd4, 4'd1, 5'd2, 1'b0, 1'b1, 8'h30, 3'd3, 7'd32, 1'b0},
    '{2'd1, 5'd16, 4'd3, 5'd4, 1'b0, 1'b0, 8'h14, 3'd4, 7'd64, 1'b1},
    '{2'd2, 5'd4, 4'd1, 5'd2, 1'b1, 1'b0, 8'h30, 3'd1, 7'd32, 1'b0},
    '{2'd0, 5'd1, 4'd0, 5'd0, 1'b1, 1'b1, 8'h18, 3'd2, 7'd20, 1'b1}
  };

  task automatic set_cfg(input int md, input int w, input int g, input int sh,
                         input bit cyc, input bit grp, input int sc, input int ln);
    cfg_mode = 2'(md); cfg_win = WW'(w); cfg_guard = GW'(g); cfg_shift = SH_W'(sh);
    cfg_cyclic = cyc; cfg_group = grp; cfg_scale = SC_W'(sc); cfg_len = LW'(ln);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 det_valid in reset", int'(det_valid), 0);
    chk("R9 busy in reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 det_valid after reset", int'(det_valid), 0);
    chk("R9 busy after reset", int'(busy), 0);

    foreach (VECS[v]) begin
      set_cfg(int'(VECS[v].mode), int'(VECS[v].win), int'(VECS[v].grd), int'(VECS[v].sh),
              VECS[v].cyc, VECS[v].grp, int'(VECS[v].sc), int'(VECS[v].len));
      cfg_dir = VECS[v].dir;
      run_line(int'(VECS[v].pat), 1'b0);
      compare_all($sformatf("vec%0d", v));
    end
    cfg_dir = 0;

    // R2 R4 spikes on flat floor
    set_cfg(0, 4, 1, 2, 0, 0, 8'h30, 32);
    run_line(0, 1'b0);
    chk("R2 spike count", cap_n, 2);
    chk("R2 first index", cap_idx[0], 10);
    chk("R2 first noise", cap_noise[0], 8);
    chk("R8 last on second", cap_last[1], 1);

    // R4 strict threshold; R2 shift changes average
    run_line(5, 1'b0);
    chk("R4 equal cell not detected", find(8), -1);
    chk("R4 one above detected", (find(20) >= 0) ? 1 : 0, 1);
    set_cfg(0, 4, 1, 3, 0, 0, 8'h30, 32);
    run_line(5, 1'b0);
    chk("R2 shift 3 detects 24", (find(8) >= 0) ? 1 : 0, 1);
    if (find(8) >= 0) chk("R2 shift 3 noise", cap_noise[find(8)], 4);

    // R3 modes
    set_cfg(0, 4, 1, 2, 0, 0, 8'h30, 32);
    run_line(2, 1'b0);
    chk("R3 mean mode hit", (find(10) >= 0) ? 1 : 0, 1);
    if (find(10) >= 0) chk("R3 mean noise", cap_noise[find(10)], 14);
    cfg_mode = 1; run_line(2, 1'b0);
    chk("R3 greater-of misses", find(10), -1);
    cfg_mode = 2; run_line(2, 1'b0);
    if (find(10) >= 0) chk("R3 smaller-of noise", cap_noise[find(10)], 8);
    else chk("R3 smaller-of hit", 0, 1);

    // R5 R6 edges
    set_cfg(0, 4, 1, 2, 0, 0, 8'h30, 32);
    run_line(1, 1'b0);
    if (find(1) >= 0) chk("R5 one-sided noise", cap_noise[find(1)], 8);
    else chk("R5 edge hit", 0, 1);
    compare_all("R5 list");
    cfg_cyclic = 1; run_line(1, 1'b0);
    if (find(1) >= 0) chk("R6 wrapped noise", cap_noise[find(1)], 24);
    else chk("R6 wrapped hit", 0, 1);
    compare_all("R6 list");

    // R7 grouping
    cfg_cyclic = 0; run_line(3, 1'b0);
    chk("R7 off keeps 11", (find(11) >= 0) ? 1 : 0, 1);
    cfg_group = 1; run_line(3, 1'b0);
    chk("R7 on drops 11", find(11), -1);
    chk("R7 on keeps 10", (find(10) >= 0) ? 1 : 0, 1);

    // R1 input and config ignored while busy
    set_cfg(0, 4, 1, 2, 0, 0, 8'h30, 32);
    run_line(2, 1'b1);
    compare_all("R1 busy junk");

    // R8 quiet line gives no pulse
    set_cfg(0, 4, 1, 2, 0, 0, 8'hF0, 32);
    run_line(0, 1'b0);
    chk("R8 no detections", cap_n, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule